// File: doc/BRIEF.md
# Presettable Split Decade Counter

A four-bit decade counter made of two sections with separate count strobes. A divide-by-two stage holds bit 0 of the count. A divide-by-five stage holds bits 3 to 1. A mode input chooses how the two stages chain together.

In BCD mode the count runs 0 to 9 with 8-4-2-1 weighting. In bi-quinary mode bit 0 becomes the most significant digit and gives a square wave at one tenth of the strobe rate.

Both strobes are sampled on one system clock, and their high-to-low transitions are found against a registered copy, so the whole block is synchronous. An asynchronous active-low clear has priority over everything else. An active-low preset loads four data bits and keeps following them for as long as it is held low.

Top module: `split_decade_counter`

## Requirements
- R1: While rst_ni is low, count_o is 4'b0000 without waiting for a clock edge, whatever load_ni, data_i and the strobes do.
- R2: At every clock edge where load_ni is low, count_o takes data_i, with data_i[i] going to count_o[i]. Strobe transitions during that time change nothing else.
- R3: While load_ni stays low, a change on data_i appears on count_o at the next clock edge.
- R4: After load_ni returns high, counting resumes from the loaded value on the first strobe fall. A strobe that fell while load_ni was low is not counted.
- R5: With mode_i = 0 (BCD), each fall of strobe_a_i toggles count_o[0] at that clock edge. When count_o[0] goes from 1 to 0, count_o[3:1] advances one clock later. count_o steps 0,1,...,9 and wraps to 0. strobe_b_i is ignored.
- R6: With mode_i = 1 (bi-quinary), each fall of strobe_b_i advances count_o[3:1] through 000, 001, 010, 011, 100 and back to 000. When count_o[3] goes from 1 to 0, count_o[0] toggles one clock later. strobe_a_i is ignored.
- R7: In bi-quinary mode, after n strobe_b_i falls from zero, count_o equals {n mod 5, n div 5} for n = 0 to 9. This keeps count_o[0] high for five of every ten falls.
- R8: If count_o[3:1] holds 101, 110 or 111, the next advance of that section sets it to 000. In bi-quinary mode that advance also toggles count_o[0].
- R9: A strobe counts only when it is high at one clock edge and low at the next. A rising transition, or a strobe held low, causes no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_ni | input | 1 | Preset enable, active low |
| data_i | input | 4 | Preset value, bit i goes to count bit i |
| mode_i | input | 1 | Cascade select: 0 BCD, 1 bi-quinary |
| strobe_a_i | input | 1 | Count strobe for the divide-by-two stage (BCD mode) |
| strobe_b_i | input | 1 | Count strobe for the divide-by-five stage (bi-quinary mode) |
| count_o | output | 4 | Count, bit 0 from divide-by-two, bits 3:1 from divide-by-five |

## Verification
The counter is driven through more than a full cycle in each mode. A BCD run that shows 8 and 9 followed by 0 separates a correct carry from one that fires on the wrong transition of bit 0. A bi-quinary run checks the {n mod 5, n div 5} pattern, which shows that the carry comes from the top bit of the divide-by-five stage and not from bit 0. Pulses on the unused strobe show that each mode routes only its own input. Presets of 101 and 111 into the upper section exercise the illegal-state recovery. A strobe that falls during a preset confirms that the edge detector keeps tracking the strobe while the preset is held.

// File: rtl/split_decade_pkg.sv
package split_decade_pkg;
  typedef enum logic {
    MODE_BCD = 1'b0,
    MODE_BIQ = 1'b1
  } cascade_mode_e;
endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= strobe_i;

  assign fall_o = prev_q & ~strobe_i;
endmodule

// File: rtl/modn_stage.sv
// Modulo-MOD stage; any value >= MOD-1 wraps to zero on advance.
// carry_o pulses one clock after a wrap (the top bit falling).
module modn_stage #(
  parameter int MOD = 5,
  localparam int W  = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         adv_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] val_q;
  logic         wrap;

  assign wrap = val_q >= LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '0;
      carry_o <= 1'b0;
    end else if (load_i) begin
      val_q   <= load_val_i;
      carry_o <= 1'b0;
    end else begin
      carry_o <= adv_i & wrap;
      if (adv_i) val_q <= wrap ? '0 : val_q + W'(1);
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter
  import split_decade_pkg::*;
#(
  parameter int LO_MOD = 2,
  parameter int HI_MOD = 5,
  localparam int LO_W  = (LO_MOD > 2) ? $clog2(LO_MOD) : 1,
  localparam int HI_W  = (HI_MOD > 2) ? $clog2(HI_MOD) : 1,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [CNT_W-1:0] data_i,
  input  logic             mode_i,
  input  logic             strobe_a_i,
  input  logic             strobe_b_i,
  output logic [CNT_W-1:0] count_o
);
  cascade_mode_e mode;
  logic fall_a, fall_b;
  logic carry_lo, carry_hi;
  logic adv_lo, adv_hi;
  logic [LO_W-1:0] lo_val;
  logic [HI_W-1:0] hi_val;
  logic load;

  assign mode = cascade_mode_e'(mode_i);
  assign load = ~load_ni;

  strobe_fall_det i_fall_a (
    .clk_i, .rst_ni, .strobe_i(strobe_a_i), .fall_o(fall_a)
  );
  strobe_fall_det i_fall_b (
    .clk_i, .rst_ni, .strobe_i(strobe_b_i), .fall_o(fall_b)
  );

  // Each mode routes one external strobe; the other stage runs off the internal carry.
  assign adv_lo = (mode == MODE_BCD) ? fall_a   : carry_hi;
  assign adv_hi = (mode == MODE_BCD) ? carry_lo : fall_b;

  modn_stage #(.MOD(LO_MOD)) i_lo (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(data_i[LO_W-1:0]),
    .adv_i(adv_lo), .val_o(lo_val), .carry_o(carry_lo)
  );
  modn_stage #(.MOD(HI_MOD)) i_hi (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(data_i[CNT_W-1:LO_W]),
    .adv_i(adv_hi), .val_o(hi_val), .carry_o(carry_hi)
  );

  assign count_o = {hi_val, lo_val};
endmodule

// File: rtl/split_decade_chk.sv
module split_decade_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_ni,
  input logic [3:0] data_i,
  input logic       mode_i,
  input logic [3:0] count_o,
  input logic       carry_lo_i,
  input logic       carry_hi_i,
  input logic       fall_b_i
);
  // R1
  always @(posedge clk_i)
    if (!rst_ni) clear_chk: assert (count_o == 4'd0);

  // R2
  load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni) |=> count_o == $past(data_i));

  // R5
  bcd_hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !mode_i && !carry_lo_i) |=> $stable(count_o[3:1]));

  // R6
  biq_lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && mode_i && !carry_hi_i) |=> $stable(count_o[0]));

  // R8
  hi_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && mode_i && fall_b_i) |=>
      count_o[3:1] == (($past(count_o[3:1]) >= 3'd4) ? 3'd0 : $past(count_o[3:1]) + 3'd1));
endmodule

bind split_decade_counter split_decade_chk i_chk (
  .clk_i, .rst_ni, .load_ni, .data_i, .mode_i, .count_o,
  .carry_lo_i(carry_lo), .carry_hi_i(carry_hi), .fall_b_i(fall_b)
);

// File: tb/test_split_decade_counter.sv
module test_split_decade_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1;
  logic [3:0] data = 4'd0;
  logic mode = 1'b0;
  logic sa = 1'b0, sb = 1'b0;
  logic [3:0] count;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  split_decade_counter i_split_decade_counter (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .mode_i(mode), .strobe_a_i(sa), .strobe_b_i(sb), .count_o(count)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: count=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_a();
    @(negedge clk) sa = 1'b1;
    @(negedge clk) sa = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk) sb = 1'b1;
    @(negedge clk) sb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk) rst_n = 1'b0; load_n = 1'b1; mode = m; sa = 1'b0; sb = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset state", count, 4'd0);
    do_reset(1'b0);
    @(negedge clk) load_n = 1'b0; data = 4'b1001;
    @(negedge clk) check("R2 preset before clear", count, 4'b1001);
    #1 rst_n = 1'b0;
    #1 check("R1 async clear overrides preset", count, 4'd0);
    @(negedge clk) check("R1 clear held", count, 4'd0);
    load_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_bcd();
    do_reset(1'b0);
    for (int n = 1; n <= 12; n++) begin
      pulse_a();
      check($sformatf("R5 bcd step %0d", n), count, 4'(n % 10));
    end
    pulse_b();
    check("R5 strobe_b ignored in bcd", count, 4'd2);
  endtask

  task automatic t_load();
    do_reset(1'b0);
    @(negedge clk) load_n = 1'b0; data = 4'b1011;
    @(negedge clk) check("R2 preset value", count, 4'b1011);
    data = 4'b0110;
    @(negedge clk) check("R3 transparent follow", count, 4'b0110);
    sa = 1'b1;
    @(negedge clk) sa = 1'b0;
    @(negedge clk) check("R2 strobe ignored in preset", count, 4'b0110);
    sa = 1'b1;
    @(negedge clk);
    @(negedge clk) load_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 no count on release", count, 4'b0110);
    sa = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 resume from preset", count, 4'd7);
    // strobe falls while preset held: must not count later
    @(negedge clk) load_n = 1'b0; data = 4'd3;
    @(negedge clk) sa = 1'b1;
    @(negedge clk) sa = 1'b0;
    @(negedge clk) load_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 fall during preset dropped", count, 4'd3);
  endtask

  task automatic t_biq();
    int highs = 0;
    do_reset(1'b1);
    for (int n = 1; n <= 10; n++) begin
      pulse_b();
      check($sformatf("R7 biq step %0d", n), count, 4'((((n % 10) % 5) << 1) | ((n % 10) / 5)));
      if (count[0]) highs++;
    end
    check("R7 duty five of ten", 4'(highs), 4'd5);
    pulse_b();
    pulse_a();
    check("R6 strobe_a ignored in biq", count, 4'b0010);
  endtask

  task automatic t_illegal();
    do_reset(1'b0);
    @(negedge clk) load_n = 1'b0; data = 4'b1111;
    @(negedge clk) load_n = 1'b1;
    pulse_a();
    check("R8 bcd 111 wraps", count, 4'd0);
    do_reset(1'b1);
    @(negedge clk) load_n = 1'b0; data = 4'b1010;
    @(negedge clk) load_n = 1'b1;
    pulse_b();
    check("R8 biq 101 wraps and toggles", count, 4'b0001);
  endtask

  task automatic t_edges();
    do_reset(1'b1);
    @(negedge clk) sb = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 rise does not count", count, 4'd0);
    sb = 1'b0;
    repeat (8) @(negedge clk);
    check("R9 held low counts once", count, 4'b0010);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bcd();
    t_load();
    t_biq();
    t_illegal();
    t_edges();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule